// File: doc/BRIEF.md
# Reordering Search-Key Scheduler for a Two-Stage Match Array

This block sits in front of a content-addressable word array whose compare runs in two stages. The first stage looks only at the lowest `LOW_W` bits of the search key. The second stage resolves the remaining bits, and only for words whose first stage hit. Two searches that follow each other directly can overlap only when their low sub-words differ. When they are equal, the array has to let the first search finish both stages before it accepts the next one. This is slow mode, and it costs one dead cycle.

The scheduler takes keys on a valid/ready stream and holds up to `LOOKAHEAD` of them in a compacted queue. It also has one spare register. Each cycle it chooses which key to send so that the low sub-word differs from the key sent in the previous cycle. It can take the spare in place of a clashing head key, or pull a later queued key forward and park the head in the spare. When no choice avoids a clash, it sends the head in slow mode. Each key carries a sequence tag, given in arrival order, so that results can be put back in order downstream. A parked key can be passed over at most `LOOKAHEAD` times before it is forced out.

A two-state controller paces the issues. In `ST_RUN` one key may issue per cycle. A slow issue moves the controller to `ST_SLOW`, where nothing issues for one cycle, and it then always returns to `ST_RUN`. In `ST_RUN`, any issue other than a slow one keeps the controller in `ST_RUN`. The issue choice in `ST_RUN` uses the following priorities, highest first:
- FORCE: the spare has reached its limit.
- HEAD: the head key does not clash.
- SWAP: the head clashes and the spare does not.
- PARK: the head clashes, the spare is empty and a later queued key does not clash.
- HEAD sent slow: none of the above applies and the queue is not empty.
- SPARE: the queue is empty.
- NONE: nothing is waiting.

Top module: `overlap_sched`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A key is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 exactly while `LOOKAHEAD` keys are queued, and the spare does not count toward this. Tags count accepted keys from 0 after reset, modulo 2^`TAG_W`.
- R3: Every accepted key leaves exactly once on `out_key`, with its own tag on `out_tag`.
- R4: The head key issues with `out_slow`=0 when its low `LOW_W` bits differ from those of the key issued in the previous cycle. It also issues with `out_slow`=0 when no key issued in the previous cycle.
- R5: An issue with `out_slow`=1 is followed by one cycle in which nothing issues.
- R6: If the head key clashes and the spare holds a key that does not clash, the spare key issues with `out_slow`=0 and the head key moves into the spare.
- R7: If the head key clashes, the spare is empty and a later queued key does not clash, the earliest such key issues with `out_slow`=0 and the head key moves into the spare.
- R8: `out_slow`=1 only when the issued key's low `LOW_W` bits equal those of the key issued in the previous cycle.
- R9: Once `LOOKAHEAD` queued keys have issued while one key sat in the spare, the next issue slot goes to the spare key.
- R10: With the queue empty and the spare occupied, the spare key issues, in slow mode only if it clashes.
- R11: Apart from a pull-forward under R7, queued keys issue in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A search key is offered |
| in_ready | output | 1 | The queue has room for a key |
| in_key | input | KEY_W | Offered search key |
| out_valid | output | 1 | A key is issued to the array this cycle |
| out_key | output | KEY_W | Issued key |
| out_tag | output | TAG_W | Arrival sequence tag of the issued key |
| out_slow | output | 1 | 1 = slow-mode issue (both stages before the next key), 0 = fast |

## Verification
The assertions check on every cycle that the issued stream follows the mode rules. A fast issue never repeats the previous low sub-word, a slow issue always does, and a slow issue is always followed by an idle cycle. They also check that a spare key at its limit takes the next slot in `ST_RUN`, that the queue stays compacted, and that only live entries are removed. Only the bench scenarios can show the rest. That covers the exact order produced by swaps, pull-forwards and forced drains, tags staying attached to their keys, backpressure appearing after a slow stall, and every key coming out exactly once.

// File: rtl/osched_pkg.sv
package osched_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_SLOW = 1'b1
    } sched_state_e;

    typedef enum logic [2:0] {
        PK_NONE  = 3'd0,
        PK_FORCE = 3'd1,
        PK_HEAD  = 3'd2,
        PK_SWAP  = 3'd3,
        PK_PARK  = 3'd4,
        PK_SPARE = 3'd5
    } pick_kind_e;

endpackage

// File: rtl/osched_queue.sv
module osched_queue #(
    parameter int DEPTH = 3,
    parameter int EW    = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [EW-1:0]             push_ent,
    input  logic [DEPTH-1:0]          rm,
    output logic [DEPTH-1:0][EW-1:0]  ents,
    output logic [DEPTH-1:0]          vld,
    output logic                      full
);

    logic [DEPTH-1:0][EW-1:0] q_r, q_n;
    logic [DEPTH-1:0]         v_r, v_n;

    // Compaction: survivors slide down in order, new entry lands behind them.
    always_comb begin
        int slot;
        slot = 0;
        q_n  = '0;
        v_n  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (v_r[i] && !rm[i]) begin
                q_n[slot] = q_r[i];
                v_n[slot] = 1'b1;
                slot      = slot + 1;
            end
        end
        if (push && slot < DEPTH) begin
            q_n[slot] = push_ent;
            v_n[slot] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
            v_r <= '0;
        end else begin
            q_r <= q_n;
            v_r <= v_n;
        end
    end

    assign ents = q_r;
    assign vld  = v_r;
    assign full = &v_r;

    // R11: live entries always occupy the low slots, so slot order is arrival order
    assert_queue_packed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (v_r & (v_r + {{(DEPTH-1){1'b0}}, 1'b1})) == '0);

    // R3: the picker only removes entries that hold a key
    assert_remove_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rm & ~v_r) == '0);

endmodule

// File: rtl/osched_spare.sv
module osched_spare #(
    parameter int EW    = 12,
    parameter int LIMIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [EW-1:0] load_ent,
    input  logic          take,
    input  logic          bypass,
    output logic [EW-1:0] ent,
    output logic          vld,
    output logic          forced
);

    localparam int AGE_W = $clog2(LIMIT + 1);

    logic [EW-1:0]    ent_r;
    logic             vld_r;
    logic [AGE_W-1:0] age_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_r <= '0;
            vld_r <= 1'b0;
            age_r <= '0;
        end else if (load) begin
            ent_r <= load_ent;
            vld_r <= 1'b1;
            age_r <= '0;
        end else if (take) begin
            vld_r <= 1'b0;
            age_r <= '0;
        end else if (bypass && vld_r && age_r < AGE_W'(LIMIT)) begin
            age_r <= age_r + AGE_W'(1);
        end
    end

    assign ent    = ent_r;
    assign vld    = vld_r;
    assign forced = vld_r && (age_r == AGE_W'(LIMIT));

    // R9: a spare at its limit is never passed over again
    assert_forced_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        forced |-> !bypass);

    // R7: parking a head key without a swap needs an empty spare
    assert_park_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !take) |-> !vld_r);

endmodule

// File: rtl/osched_pick.sv
module osched_pick
    import osched_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int EW    = 12,
    parameter int LOW_W = 2
) (
    input  logic                      en,
    input  logic [DEPTH-1:0][EW-1:0]  q_ents,
    input  logic [DEPTH-1:0]          q_vld,
    input  logic [EW-1:0]             sp_ent,
    input  logic                      sp_vld,
    input  logic                      sp_forced,
    input  logic                      prev_vld,
    input  logic [LOW_W-1:0]          prev_low,
    output logic                      issue,
    output logic [EW-1:0]             iss_ent,
    output logic                      iss_slow,
    output logic [DEPTH-1:0]          rm,
    output logic                      sp_load,
    output logic [EW-1:0]             sp_load_ent,
    output logic                      sp_take,
    output logic                      bypass
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    function automatic logic clash(input logic [EW-1:0] e,
                                   input logic pv,
                                   input logic [LOW_W-1:0] pl);
        return pv && (e[LOW_W-1:0] == pl);
    endfunction

    logic          head_cf, sp_cf, alt_found;
    logic [IW-1:0] alt_idx;
    pick_kind_e    kind;

    always_comb begin
        head_cf = clash(q_ents[0], prev_vld, prev_low);
        sp_cf   = clash(sp_ent, prev_vld, prev_low);
        alt_found = 1'b0;
        alt_idx   = '0;
        for (int i = 1; i < DEPTH; i++) begin
            if (!alt_found && q_vld[i] && !clash(q_ents[i], prev_vld, prev_low)) begin
                alt_found = 1'b1;
                alt_idx   = IW'(i);
            end
        end
    end

    always_comb begin
        if (!en)                                  kind = PK_NONE;
        else if (sp_forced)                       kind = PK_FORCE;
        else if (q_vld[0] && !head_cf)            kind = PK_HEAD;
        else if (q_vld[0] && sp_vld && !sp_cf)    kind = PK_SWAP;
        else if (q_vld[0] && !sp_vld && alt_found) kind = PK_PARK;
        else if (q_vld[0])                        kind = PK_HEAD;
        else if (sp_vld)                          kind = PK_SPARE;
        else                                      kind = PK_NONE;
    end

    always_comb begin
        issue       = 1'b0;
        iss_ent     = '0;
        iss_slow    = 1'b0;
        rm          = '0;
        sp_load     = 1'b0;
        sp_load_ent = q_ents[0];
        sp_take     = 1'b0;
        bypass      = 1'b0;
        unique case (kind)
            PK_NONE: begin
                issue = 1'b0;
            end
            PK_FORCE, PK_SPARE: begin
                issue    = 1'b1;
                iss_ent  = sp_ent;
                iss_slow = sp_cf;
                sp_take  = 1'b1;
            end
            PK_HEAD: begin
                issue    = 1'b1;
                iss_ent  = q_ents[0];
                iss_slow = head_cf;
                rm[0]    = 1'b1;
                bypass   = sp_vld;
            end
            PK_SWAP: begin
                issue   = 1'b1;
                iss_ent = sp_ent;
                rm[0]   = 1'b1;
                sp_take = 1'b1;
                sp_load = 1'b1;
            end
            PK_PARK: begin
                issue       = 1'b1;
                iss_ent     = q_ents[alt_idx];
                rm[0]       = 1'b1;
                rm[alt_idx] = 1'b1;
                sp_load     = 1'b1;
            end
            default: begin
                issue = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/overlap_sched.sv
module overlap_sched
    import osched_pkg::*;
#(
    parameter int KEY_W     = 8,
    parameter int LOW_W     = 2,
    parameter int LOOKAHEAD = 3,
    parameter int TAG_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [KEY_W-1:0] in_key,
    output logic             out_valid,
    output logic [KEY_W-1:0] out_key,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_slow
);

    localparam int EW = KEY_W + TAG_W;

    sched_state_e state_r, state_n;

    logic [TAG_W-1:0]              tag_r;
    logic                          push, q_full;
    logic [LOOKAHEAD-1:0][EW-1:0]  q_ents;
    logic [LOOKAHEAD-1:0]          q_vld, rm;
    logic [EW-1:0]                 sp_ent, sp_load_ent, iss_ent;
    logic                          sp_vld, sp_forced, sp_load, sp_take, bypass;
    logic                          issue, iss_slow;

    assign in_ready = !q_full;
    assign push     = in_valid && in_ready;

    osched_queue #(.DEPTH(LOOKAHEAD), .EW(EW)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_ent ({tag_r, in_key}),
        .rm       (rm),
        .ents     (q_ents),
        .vld      (q_vld),
        .full     (q_full)
    );

    osched_spare #(.EW(EW), .LIMIT(LOOKAHEAD)) u_spare (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sp_load),
        .load_ent (sp_load_ent),
        .take     (sp_take),
        .bypass   (bypass),
        .ent      (sp_ent),
        .vld      (sp_vld),
        .forced   (sp_forced)
    );

    osched_pick #(.DEPTH(LOOKAHEAD), .EW(EW), .LOW_W(LOW_W)) u_pick (
        .en          (state_r == ST_RUN),
        .q_ents      (q_ents),
        .q_vld       (q_vld),
        .sp_ent      (sp_ent),
        .sp_vld      (sp_vld),
        .sp_forced   (sp_forced),
        .prev_vld    (out_valid),
        .prev_low    (out_key[LOW_W-1:0]),
        .issue       (issue),
        .iss_ent     (iss_ent),
        .iss_slow    (iss_slow),
        .rm          (rm),
        .sp_load     (sp_load),
        .sp_load_ent (sp_load_ent),
        .sp_take     (sp_take),
        .bypass      (bypass)
    );

    // Next-state logic
    always_comb begin
        state_n = state_r;
        unique case (state_r)
            ST_RUN:  state_n = (issue && iss_slow) ? ST_SLOW : ST_RUN;
            ST_SLOW: state_n = ST_RUN;
            default: state_n = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_r <= ST_RUN;
        else        state_r <= state_n;
    end

    // Registered issue outputs and arrival tag counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_key   <= '0;
            out_tag   <= '0;
            out_slow  <= 1'b0;
            tag_r     <= '0;
        end else begin
            out_valid <= issue;
            out_slow  <= issue && iss_slow;
            if (issue) begin
                out_key <= iss_ent[KEY_W-1:0];
                out_tag <= iss_ent[EW-1:KEY_W];
            end
            if (push) tag_r <= tag_r + TAG_W'(1);
        end
    end

    // R5: a slow issue leaves the next cycle empty
    assert_slow_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_slow) |=> !out_valid);

    // R4: back-to-back fast issues never share a low sub-word
    assert_fast_differs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_slow && $past(out_valid))
        |-> (out_key[LOW_W-1:0] != $past(out_key[LOW_W-1:0])));

    // R8: slow mode is used only for a real clash with the previous issue
    assert_slow_justified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_slow)
        |-> ($past(out_valid) && out_key[LOW_W-1:0] == $past(out_key[LOW_W-1:0])));

    // R9: a spare at its limit takes the very next issue slot
    assert_forced_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == ST_RUN && sp_forced)
        |=> (out_valid && out_tag == $past(sp_ent[EW-1:KEY_W])));

endmodule

// File: tb/tb_overlap_sched.sv
module tb_overlap_sched;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_key = '0;
    logic       out_valid;
    logic [7:0] out_key;
    logic [3:0] out_tag;
    logic       out_slow;

    int checks = 0;
    int errors = 0;
    int ev_n   = 0;
    int stalls = 0;
    int phase  = 0;
    logic slow_seen = 1'b0;

    always #5 clk = ~clk;

    overlap_sched dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key),
        .out_valid(out_valid), .out_key(out_key), .out_tag(out_tag), .out_slow(out_slow)
    );

    // Stimulus: key = index*4 + low sub-word
    localparam logic [7:0] MAIN_STIM [14] = '{
        8'd0, 8'd4, 8'd9, 8'd13, 8'd18, 8'd22, 8'd27,
        8'd28, 8'd33, 8'd38, 8'd42, 8'd47, 8'd48, 8'd55};

    // Expected issue stream {key, tag, slow}
    localparam logic [12:0] MAIN_EXP [14] = '{
        {8'd0,  4'd0,  1'b0},
        {8'd4,  4'd1,  1'b1},   // R8 clash, no fix
        {8'd9,  4'd2,  1'b0},   // R4 after idle cycle
        {8'd18, 4'd4,  1'b0},   // R7 pulled forward, key 13 parked
        {8'd13, 4'd3,  1'b0},   // R6 swap, key 22 parked
        {8'd27, 4'd6,  1'b0},
        {8'd28, 4'd7,  1'b0},
        {8'd33, 4'd8,  1'b0},
        {8'd22, 4'd5,  1'b0},   // R9 forced out of spare
        {8'd38, 4'd9,  1'b1},   // R8 every choice clashes
        {8'd42, 4'd10, 1'b0},
        {8'd47, 4'd11, 1'b0},
        {8'd48, 4'd12, 1'b0},
        {8'd55, 4'd13, 1'b0}};

    localparam logic [7:0] DIR_STIM [5] = '{8'h80, 8'h84, 8'h89, 8'h8D, 8'h92};
    localparam logic [12:0] DIR_EXP [5] = '{
        {8'h80, 4'd0, 1'b0},
        {8'h84, 4'd1, 1'b1},
        {8'h89, 4'd2, 1'b0},
        {8'h92, 4'd4, 1'b0},
        {8'h8D, 4'd3, 1'b0}};  // R10 spare drains with queue empty

    function automatic logic [12:0] exp_at(input int ph, input int idx);
        if (ph == 0) return (idx < 14) ? MAIN_EXP[idx] : 13'd0;
        return (idx < 5) ? DIR_EXP[idx] : 13'd0;
    endfunction

    function automatic int exp_len(input int ph);
        return (ph == 0) ? 14 : 5;
    endfunction

    // Issue monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            ev_n      = 0;
            slow_seen = 1'b0;
        end else begin
            if (slow_seen) begin
                checks++;
                if (out_valid) begin
                    errors++;
                    $display("FAIL R5 bubble: out_valid=%0b expected 0", out_valid);
                end
            end
            slow_seen = out_valid && out_slow;
            if (out_valid) begin
                logic [12:0] e;
                e = exp_at(phase, ev_n);
                checks++;
                if (ev_n >= exp_len(phase) || {out_key, out_tag} != e[12:1]) begin
                    errors++;
                    $display("FAIL R3/R11 issue %0d: key=%0d tag=%0d expected key=%0d tag=%0d",
                             ev_n, out_key, out_tag, e[12:5], e[4:1]);
                end
                checks++;
                if (out_slow != e[0]) begin
                    errors++;
                    $display("FAIL R4/R8 mode of issue %0d: slow=%0b expected %0b",
                             ev_n, out_slow, e[0]);
                end
                ev_n++;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: in_ready=%0b out_valid=%0b expected 1 0", in_ready, out_valid);
        end
    endtask

    task automatic send(input logic [7:0] k);
        in_valid = 1'b1;
        in_key   = k;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_eq(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // Table-driven stream covering R2 R4 R6 R7 R8 R9
        phase = 0;
        do_reset();
        stalls = 0;
        for (int i = 0; i < 14; i++) send(MAIN_STIM[i]);
        repeat (10) @(negedge clk);
        check_eq("R3 issue count main", ev_n, 14);
        check_eq("R2 backpressure cycles", stalls, 1);
        check_eq("R2 ready after drain", int'(in_ready), 1);

        // Directed: spare drains when the queue runs dry (R10), tags restart (R2)
        phase = 1;
        do_reset();
        for (int i = 0; i < 5; i++) send(DIR_STIM[i]);
        repeat (10) @(negedge clk);
        check_eq("R10 issue count directed", ev_n, 5);
        check_eq("R1 idle after drain", int'(out_valid), 0);

        finish_run();
    end

endmodule